// File: doc/BRIEF.md
# Pipeline Trap Commit Controller

This block is the exception control for an in-order five-stage pipeline: fetch, decode, execute, memory, writeback. Each stage has its own fault detector, and the block sees only that detector's flag. A fetch address fault, an illegal opcode, an arithmetic overflow and a data address fault are not acted on where they are found. Each one is written into a small record that travels with the instruction: a valid bit, an exception bit, a cause code and the PC. The memory stage is the single commit point. There the block merges the record with the memory-stage fault and with any pending external interrupt, and decides whether to trap.

When a trap is taken, several things happen together. The block records the cause and the exception PC. It kills every younger instruction in fetch, decode and execute, and it blocks writeback of the trapping instruction. In the next cycle it steers fetch to a fixed handler address. A killed instruction keeps a cleared valid bit from then on, so it can neither trap nor write back. The datapath around the block advances one stage per clock. The block shadows the datapath's instruction flow through `if_valid_i` and `if_pc_i`.

The sequencer has two states, RUN and REDIRECT. The transitions are TAKE (RUN to REDIRECT, when a trap is taken at commit), RESUME (REDIRECT to RUN, always the next cycle) and STAY (RUN to RUN when no trap is taken).

Top module: `trap_ctrl`

## Requirements
- R1: Cause codes, 3 bits wide: 0 external interrupt, 1 fetch address fault, 2 illegal opcode, 3 arithmetic overflow, 4 data address fault. An instruction presented at fetch in cycle t is in decode at t+1, in execute at t+2, commits in the memory stage at t+3, and writes back at t+4. `id_illegal_i`, `ex_ovf_i` and `mem_fault_i` refer to the instruction that is in that stage during the same cycle.
- R2: `trap_o` is asserted only in the cycle in which the faulting instruction is in the memory stage, never in the cycle in which its fault is detected in an earlier stage.
- R3: If `irq_i` is high while a valid instruction is in the memory stage, a trap is taken with cause 0, whatever synchronous faults that instruction carries.
- R4: When one instruction raises faults in several stages, the cause recorded is that of the earliest stage.
- R5: On the clock edge that ends a trap cycle, `cause_o` takes the trap's cause and `epc_o` takes the PC of the instruction that was in the memory stage.
- R6: A trap kills the instructions in fetch, decode and execute. None of them later traps or writes back. `kill_o` equals `trap_o`.
- R7: `redirect_o` is high, with `redirect_pc_o` equal to HANDLER_PC, exactly in the cycle after a trap, which is the REDIRECT state. It is low in every other cycle.
- R8: With no valid instruction in the memory stage, no trap is taken: `irq_i` and `mem_fault_i` are ignored in that cycle.
- R9: `cause_o` and `epc_o` hold their values in every cycle that follows a cycle without a trap.
- R10: A valid instruction that commits without a trap gives `wb_valid_o` high one cycle later, with `wb_pc_o` equal to its PC. In every other cycle `wb_valid_o` is low.
- R11: After reset, `trap_o`, `wb_valid_o` and `redirect_o` are low, `cause_o` is 0, `epc_o` is 0, and no instruction is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_valid_i | input | 1 | A valid instruction is in fetch |
| if_pc_i | input | PC_W | PC of the fetch-stage instruction |
| if_fault_i | input | 1 | Fetch address fault for the fetch-stage instruction |
| id_illegal_i | input | 1 | Illegal opcode in the decode stage |
| ex_ovf_i | input | 1 | Arithmetic overflow in the execute stage |
| mem_fault_i | input | 1 | Data address fault in the memory stage |
| irq_i | input | 1 | External asynchronous interrupt request |
| trap_o | output | 1 | A trap is taken at commit in this cycle |
| kill_o | output | 1 | Flush fetch, decode and execute |
| wb_valid_o | output | 1 | The writeback-stage instruction may write back |
| wb_pc_o | output | PC_W | PC of the writeback-stage instruction |
| cause_o | output | 3 | Recorded trap cause |
| epc_o | output | PC_W | Recorded exception PC |
| redirect_o | output | 1 | Fetch must load the handler PC |
| redirect_pc_o | output | PC_W | Handler PC |

## Verification
The bench builds the block with PC_W at 32 and HANDLER_PC overridden to 32'h8000_0040. Any design that drives a hard-wired handler address therefore shows up as a mismatch on the redirect. Fetch PCs come from a running 32-bit counter, so every EPC and writeback PC is distinct. This makes it possible to see whether the recorded PC belongs to the committing instruction or to a neighbour one stage away. Fault flags are raised at low random rates. Over a long random run, faults of different stages on one instruction, interrupts against both full and empty memory slots, and back-to-back faulting instructions behind a trap all occur.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ        = 3'd0,
        CAUSE_FETCH_ADDR = 3'd1,
        CAUSE_ILLEGAL    = 3'd2,
        CAUSE_OVERFLOW   = 3'd3,
        CAUSE_DATA_ADDR  = 3'd4
    } cause_e;

    typedef enum logic [0:0] {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/trap_stage.sv
// One pipeline slot of exception state. The record of the incoming instruction
// is merged with this slot's local detector. A fault that is already recorded
// keeps its cause, so the earliest stage wins.
module trap_stage
    import trap_pkg::*;
#(
    parameter int     PC_W      = 32,
    parameter cause_e DET_CAUSE = CAUSE_FETCH_ADDR
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            kill_i,
    input  logic            in_valid_i,
    input  logic            in_exc_i,
    input  cause_e          in_cause_i,
    input  logic [PC_W-1:0] in_pc_i,
    input  logic            det_i,
    output logic            out_valid_o,
    output logic            out_exc_o,
    output cause_e          out_cause_o,
    output logic [PC_W-1:0] out_pc_o
);
    logic   hit;
    cause_e merged_cause;

    always_comb begin
        hit          = in_valid_i & (in_exc_i | det_i);
        merged_cause = in_exc_i ? in_cause_i : DET_CAUSE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_valid_o <= 1'b0;
            out_exc_o   <= 1'b0;
            out_cause_o <= CAUSE_IRQ;
            out_pc_o    <= '0;
        end else if (kill_i) begin
            out_valid_o <= 1'b0;
            out_exc_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            out_exc_o   <= hit;
            out_cause_o <= merged_cause;
            out_pc_o    <= in_pc_i;
        end
    end
endmodule

// File: rtl/trap_commit.sv
// Commit decision for the memory stage. An interrupt outranks every
// synchronous fault. A fault carried from an earlier stage outranks the
// memory-stage data fault.
module trap_commit
    import trap_pkg::*;
(
    input  logic   m_valid_i,
    input  logic   m_exc_i,
    input  cause_e m_cause_i,
    input  logic   mem_fault_i,
    input  logic   irq_i,
    output logic   take_o,
    output cause_e cause_o
);
    always_comb begin
        take_o  = m_valid_i & (irq_i | m_exc_i | mem_fault_i);
        if (irq_i) begin
            cause_o = CAUSE_IRQ;
        end else if (m_exc_i) begin
            cause_o = m_cause_i;
        end else begin
            cause_o = CAUSE_DATA_ADDR;
        end
    end
endmodule

// File: rtl/trap_fsm.sv
// Trap sequencer, with the cause and exception-PC registers and the
// writeback stage.
module trap_fsm
    import trap_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            take_i,
    input  cause_e          cause_i,
    input  logic            m_valid_i,
    input  logic [PC_W-1:0] m_pc_i,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output cause_e          cause_q_o,
    output logic [PC_W-1:0] epc_q_o,
    output logic            wb_valid_o,
    output logic [PC_W-1:0] wb_pc_o
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      state_d = take_i ? ST_REDIRECT : ST_RUN;      // TAKE / STAY
            ST_REDIRECT: state_d = take_i ? ST_REDIRECT : ST_RUN;      // RESUME
            default:     state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        redirect_o    = 1'b0;
        redirect_pc_o = '0;
        unique case (state_q)
            ST_RUN: begin
                redirect_o    = 1'b0;
            end
            ST_REDIRECT: begin
                redirect_o    = 1'b1;
                redirect_pc_o = HANDLER_PC;
            end
            default: begin
                redirect_o    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cause_q_o <= CAUSE_IRQ;
            epc_q_o   <= '0;
        end else if (take_i) begin
            cause_q_o <= cause_i;
            epc_q_o   <= m_pc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wb_valid_o <= 1'b0;
            wb_pc_o    <= '0;
        end else begin
            wb_valid_o <= m_valid_i & ~take_i;
            wb_pc_o    <= m_pc_i;
        end
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              if_valid_i,
    input  logic [PC_W-1:0]   if_pc_i,
    input  logic              if_fault_i,
    input  logic              id_illegal_i,
    input  logic              ex_ovf_i,
    input  logic              mem_fault_i,
    input  logic              irq_i,
    output logic              trap_o,
    output logic              kill_o,
    output logic              wb_valid_o,
    output logic [PC_W-1:0]   wb_pc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [PC_W-1:0]   epc_o,
    output logic              redirect_o,
    output logic [PC_W-1:0]   redirect_pc_o
);
    // Slots 0..2 hold decode, execute and memory. Detector k acts on the
    // instruction entering slot k.
    localparam int NSTG = 3;

    logic [NSTG-1:0]  s_valid, s_exc;
    cause_e           s_cause [NSTG];
    logic [PC_W-1:0]  s_pc    [NSTG];
    logic [NSTG-1:0]  det_vec;
    logic             take;
    cause_e           take_cause;
    cause_e           cause_q;
    logic             m_valid;
    logic [PC_W-1:0]  m_pc;

    assign det_vec = {ex_ovf_i, id_illegal_i, if_fault_i};

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        localparam cause_e STG_CAUSE = (k == 0) ? CAUSE_FETCH_ADDR :
                                       (k == 1) ? CAUSE_ILLEGAL : CAUSE_OVERFLOW;
        logic            in_valid, in_exc;
        cause_e          in_cause;
        logic [PC_W-1:0] in_pc;
        if (k == 0) begin : g_head
            assign in_valid = if_valid_i;
            assign in_exc   = 1'b0;
            assign in_cause = CAUSE_IRQ;
            assign in_pc    = if_pc_i;
        end else begin : g_link
            assign in_valid = s_valid[k-1];
            assign in_exc   = s_exc[k-1];
            assign in_cause = s_cause[k-1];
            assign in_pc    = s_pc[k-1];
        end
        trap_stage #(.PC_W(PC_W), .DET_CAUSE(STG_CAUSE)) u_stage (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .kill_i      (take),
            .in_valid_i  (in_valid),
            .in_exc_i    (in_exc),
            .in_cause_i  (in_cause),
            .in_pc_i     (in_pc),
            .det_i       (det_vec[k]),
            .out_valid_o (s_valid[k]),
            .out_exc_o   (s_exc[k]),
            .out_cause_o (s_cause[k]),
            .out_pc_o    (s_pc[k])
        );
    end

    assign m_valid = s_valid[NSTG-1];
    assign m_pc    = s_pc[NSTG-1];

    trap_commit u_commit (
        .m_valid_i   (m_valid),
        .m_exc_i     (s_exc[NSTG-1]),
        .m_cause_i   (s_cause[NSTG-1]),
        .mem_fault_i (mem_fault_i),
        .irq_i       (irq_i),
        .take_o      (take),
        .cause_o     (take_cause)
    );

    trap_fsm #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .take_i        (take),
        .cause_i       (take_cause),
        .m_valid_i     (m_valid),
        .m_pc_i        (m_pc),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .cause_q_o     (cause_q),
        .epc_q_o       (epc_o),
        .wb_valid_o    (wb_valid_o),
        .wb_pc_o       (wb_pc_o)
    );

    assign trap_o  = take;
    assign kill_o  = take;
    assign cause_o = cause_q;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic            trap,
    input logic            kill,
    input logic            redirect,
    input logic [PC_W-1:0] redirect_pc,
    input logic [2:0]      cause,
    input logic [PC_W-1:0] epc,
    input logic            wb_valid,
    input logic            m_valid,
    input logic [PC_W-1:0] m_pc
);
    p_trap_needs_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> m_valid);
    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && irq) |=> (cause == 3'd0));
    p_epc_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (epc == $past(m_pc)));
    p_no_wb_after_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !wb_valid);
    p_single_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);
    p_kill_with_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kill == trap);
    p_redirect_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (redirect && redirect_pc == HANDLER_PC));
    p_redirect_only_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |=> !redirect);
    p_hold_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |=> ($stable(cause) && $stable(epc)));
endmodule

bind trap_ctrl trap_ctrl_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .irq         (irq_i),
    .trap        (trap_o),
    .kill        (kill_o),
    .redirect    (redirect_o),
    .redirect_pc (redirect_pc_o),
    .cause       (cause_o),
    .epc         (epc_o),
    .wb_valid    (wb_valid_o),
    .m_valid     (m_valid),
    .m_pc        (m_pc)
);

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;
    localparam int          PC_W = 32;
    localparam logic [31:0] HPC  = 32'h8000_0040;

    logic clk = 1'b0, rst_n = 1'b0;
    logic if_valid = 0, if_fault = 0, id_illegal = 0, ex_ovf = 0, mem_fault = 0, irq = 0;
    logic [31:0] if_pc = '0;
    logic trap, kill, wb_valid, redirect;
    logic [31:0] wb_pc, epc, redirect_pc;
    logic [2:0] cause;

    trap_ctrl #(.PC_W(PC_W), .HANDLER_PC(HPC)) dut (
        .clk_i(clk), .rst_ni(rst_n), .if_valid_i(if_valid), .if_pc_i(if_pc),
        .if_fault_i(if_fault), .id_illegal_i(id_illegal), .ex_ovf_i(ex_ovf),
        .mem_fault_i(mem_fault), .irq_i(irq), .trap_o(trap), .kill_o(kill),
        .wb_valid_o(wb_valid), .wb_pc_o(wb_pc), .cause_o(cause), .epc_o(epc),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc));

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // Bench reference: slots 0..2 = decode, execute, memory.
    bit          mv [3];
    bit          mx [3];
    logic [2:0]  mc [3];
    logic [31:0] mp [3];
    bit          e_wb = 0, e_redir = 0;
    logic [31:0] e_wbpc = '0, e_epc = '0;
    logic [2:0]  e_cause = '0;
    logic [31:0] pc_ctr = 32'h100;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_trap(input bit irq_v, input bit mf);
        return mv[2] & (irq_v | mx[2] | mf);
    endfunction

    function automatic logic [2:0] exp_cause(input bit irq_v);
        if (irq_v) return 3'd0;
        if (mx[2]) return mc[2];
        return 3'd4;
    endfunction

    task automatic step(input bit v, input bit ff, input bit il, input bit ov,
                        input bit mf, input bit iq);
        bit t;
        @(negedge clk);
        if_valid = v; if_pc = pc_ctr; if_fault = ff; id_illegal = il;
        ex_ovf = ov; mem_fault = mf; irq = iq;
        #1;
        t = exp_trap(iq, mf);
        chk("R2 R8 trap", {31'd0, trap}, {31'd0, t});
        chk("R6 kill", {31'd0, kill}, {31'd0, t});
        chk("R10 wb_valid", {31'd0, wb_valid}, {31'd0, e_wb});
        if (e_wb) chk("R10 wb_pc", wb_pc, e_wbpc);
        chk("R7 redirect", {31'd0, redirect}, {31'd0, e_redir});
        if (e_redir) chk("R7 redirect_pc", redirect_pc, HPC);
        chk("R1 R3 R4 R9 cause", {29'd0, cause}, {29'd0, e_cause});
        chk("R5 R9 epc", epc, e_epc);
        // advance the model to the next edge
        e_wb = mv[2] & ~t; e_wbpc = mp[2]; e_redir = t;
        if (t) begin
            e_cause = exp_cause(iq); e_epc = mp[2];
            for (int k = 0; k < 3; k++) begin mv[k] = 0; mx[k] = 0; end
        end else begin
            mv[2] = mv[1]; mx[2] = mv[1] & (mx[1] | ov); mc[2] = mx[1] ? mc[1] : 3'd3; mp[2] = mp[1];
            mv[1] = mv[0]; mx[1] = mv[0] & (mx[0] | il); mc[1] = mx[0] ? mc[0] : 3'd2; mp[1] = mp[0];
            mv[0] = v;     mx[0] = v & ff;               mc[0] = 3'd1;                  mp[0] = pc_ctr;
        end
        pc_ctr = pc_ctr + 32'd4;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin mv[k] = 0; mx[k] = 0; mc[k] = 0; mp[k] = 0; end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 trap", {31'd0, trap}, 32'd0);
        chk("R11 wb_valid", {31'd0, wb_valid}, 32'd0);
        chk("R11 redirect", {31'd0, redirect}, 32'd0);
        chk("R11 cause", {29'd0, cause}, 32'd0);
        chk("R11 epc", epc, 32'd0);
        rst_n = 1'b1;
        // R8: interrupt and data fault with an empty memory slot
        step(0, 0, 0, 0, 1, 1);
        // R10: clean instructions flow to writeback
        repeat (5) step(1, 0, 0, 0, 0, 0);
        // R4: fetch fault and illegal opcode on the same instruction -> cause 1
        step(1, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);   // commit, trap expected (R2: no trap before)
        step(1, 0, 0, 0, 0, 0);   // R7 redirect, R6 younger ones gone
        repeat (4) step(1, 0, 0, 0, 0, 0);
        // R3: interrupt outranks a carried overflow plus a data fault
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 1, 1);
        repeat (4) step(1, 0, 0, 0, 0, 0);
        // R1: each detector alone, including the data address fault
        step(1, 0, 0, 0, 0, 0); step(1, 0, 1, 0, 0, 0); repeat (4) step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 1, 0); repeat (4) step(1, 0, 0, 0, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) != 0, ($urandom % 40) == 0, ($urandom % 40) == 0,
                 ($urandom % 40) == 0, ($urandom % 40) == 0, ($urandom % 50) == 0);
        end
        repeat (5) step(0, 0, 0, 0, 0, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule